// File: doc/BRIEF.md
# Banked 24-bit Effective Address Generator

This block forms the 24-bit bus address for a processor whose 16-bit address space is extended with bank bytes. It keeps a data bank byte, a 16-bit direct page base and a 16-bit stack pointer. It also keeps the program counter together with its program bank. Each cycle it combines a selected addressing mode with the instruction operand, a 24-bit pointer already fetched from memory, and the X or Y index. On a cycle that carries a valid-address strobe, it registers the result as the bus address.

Modes fall into two groups. The long and absolute modes do their arithmetic across the full 24 bits, so an index sum that overflows the low 16 bits moves into the next bank. The direct and stack-relative modes do their arithmetic in 16 bits and always target bank zero. The program counter also stays inside its own bank: it wraps within the 16-bit offset and never carries into the program bank.

Top module: `bank_ea_gen`

## Requirements
- R1: `pc_step` advances the 16-bit program counter by one. From 0xFFFF it wraps to 0x0000, and `pc_bank` stays unchanged.
- R2: `pc_load` loads `pc_out` from `pc_load_val[15:0]` and `pc_bank` from `pc_load_val[23:16]`. When both `pc_load` and `pc_step` are high, the load takes priority.
- R3: Mode 9 (indirect long) produces `ptr_long`. Mode 10 (indirect long, Y indexed) produces `ptr_long` plus Y, taken modulo 2^24, so a carry out of bit 15 increments the bank byte.
- R4: Mode 3 (long) produces `operand` unchanged. Mode 4 (long, X indexed) produces `operand` plus X, taken modulo 2^24.
- R5: Mode 8 (stack relative) produces bank 0x00 with offset (stack pointer + `operand[7:0]`) mod 2^16.
- R6: The direct modes always produce bank 0x00. Their offsets, taken mod 2^16, are: mode 5, direct page + `operand[7:0]`; mode 6, that sum + X; mode 7, that sum + Y. `operand[23:8]` is not used by these modes.
- R7: Mode 0 (absolute) produces {data bank, `operand[15:0]`}. Modes 1 and 2 add X or Y respectively to that 24-bit value, modulo 2^24, with the carry going into the bank byte.
- R8: While `idx_narrow` is high, bits 15:8 of X and Y are treated as zero in every indexed mode.
- R9: `bus_addr` takes the computed address on a rising edge where `addr_strobe` is high, and holds its value otherwise. Reset clears `bus_addr`, the program counter, the program bank, the data bank, the direct page and the stack pointer to zero.
- R10: On a rising edge with `reg_wr` high, `reg_sel` selects which register takes `reg_wdata`: 0 selects the data bank (from the low 8 bits), 1 the direct page, 2 the stack pointer. Code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 2 | Register write target |
| reg_wdata | input | 16 | Register write value |
| pc_load | input | 1 | Load program counter and bank |
| pc_load_val | input | 24 | Value for pc_load, bank in bits 23:16 |
| pc_step | input | 1 | Advance program counter |
| mode | input | 4 | Addressing-mode code |
| operand | input | 24 | Instruction operand bytes |
| ptr_long | input | 24 | Pointer fetched for indirect long modes |
| idx_x | input | 16 | X index |
| idx_y | input | 16 | Y index |
| idx_narrow | input | 1 | Index registers in 8-bit width |
| addr_strobe | input | 1 | Valid-address strobe, captures bus_addr |
| bus_addr | output | 24 | Registered effective address |
| pc_out | output | 16 | Program counter |
| pc_bank | output | 8 | Program bank |

## Verification
The hardest cases are the sums that cross a boundary. They only show up when a base sits just below a 64K edge and the index or offset is large enough to pass it. The bench therefore sets the direct page base to 0xFF80, chooses operands and pointers such as 0xFFF0 and 0xFFFFFF, and includes one case where the stack pointer is moved near 0xFFFF. With those settings, a carry into the bank byte (long and absolute modes) and a wrap to bank zero (direct and stack modes) both give addresses that differ visibly from the wrong alternative. The index values used with the 8-bit width flag have nonzero upper bytes, so a design that fails to mask them produces a different address.

// File: rtl/bank_ea_pkg.sv
package bank_ea_pkg;

    typedef enum logic [3:0] {
        EA_ABS        = 4'd0,
        EA_ABS_X      = 4'd1,
        EA_ABS_Y      = 4'd2,
        EA_LONG       = 4'd3,
        EA_LONG_X     = 4'd4,
        EA_DIR        = 4'd5,
        EA_DIR_X      = 4'd6,
        EA_DIR_Y      = 4'd7,
        EA_STK        = 4'd8,
        EA_IND_LONG   = 4'd9,
        EA_IND_LONG_Y = 4'd10
    } ea_mode_e;

    localparam logic [1:0] SEL_DBANK = 2'd0;
    localparam logic [1:0] SEL_DPAGE = 2'd1;
    localparam logic [1:0] SEL_STACK = 2'd2;

endpackage

// File: rtl/bank_ea_regs.sv
module bank_ea_regs #(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [OFF_W-1:0]  wdata_i,
    output logic [BANK_W-1:0] dbank_o,
    output logic [OFF_W-1:0]  dpage_o,
    output logic [OFF_W-1:0]  sp_o
);
    import bank_ea_pkg::*;

    typedef struct packed {
        logic [BANK_W-1:0] dbank;
        logic [OFF_W-1:0]  dpage;
        logic [OFF_W-1:0]  sp;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (sel_i)
                SEL_DBANK: st_d.dbank = wdata_i[BANK_W-1:0];
                SEL_DPAGE: st_d.dpage = wdata_i;
                SEL_STACK: st_d.sp    = wdata_i;
                default:   st_d       = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dbank_o = st_q.dbank;
    assign dpage_o = st_q.dpage;
    assign sp_o    = st_q.sp;

    AST_STACK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_STACK) |=> sp_o == $past(wdata_i)); // R10
    AST_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == 2'd3) |=> ($stable(dbank_o) && $stable(dpage_o) && $stable(sp_o))); // R10

endmodule

// File: rtl/bank_ea_pc.sv
module bank_ea_pc #(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    localparam int ADDR_W = BANK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [OFF_W-1:0]  pc_o,
    output logic [BANK_W-1:0] bank_o
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFF_W-1:0]  pc;
    } pc_t;

    pc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.bank = load_val_i[ADDR_W-1:OFF_W];
            st_d.pc   = load_val_i[OFF_W-1:0];
        end else if (step_i) begin
            st_d.pc   = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o   = st_q.pc;
    assign bank_o = st_q.bank;

    AST_PC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && pc_o == {OFF_W{1'b1}}) |=> (pc_o == '0 && $stable(bank_o))); // R1
    AST_PC_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i) |=> $stable(bank_o)); // R1
    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ({bank_o, pc_o} == $past(load_val_i))); // R2

endmodule

// File: rtl/bank_ea_calc.sv
module bank_ea_calc #(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    parameter int NARROW_W = 8,
    localparam int ADDR_W = BANK_W + OFF_W
) (
    input  logic [3:0]        mode_i,
    input  logic [ADDR_W-1:0] operand_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [OFF_W-1:0]  idx_x_i,
    input  logic [OFF_W-1:0]  idx_y_i,
    input  logic              narrow_i,
    input  logic [BANK_W-1:0] dbank_i,
    input  logic [OFF_W-1:0]  dpage_i,
    input  logic [OFF_W-1:0]  sp_i,
    output logic [ADDR_W-1:0] ea_o
);
    import bank_ea_pkg::*;

    logic [OFF_W-1:0] x_eff, y_eff;

    generate
        if (OFF_W > NARROW_W) begin : g_narrow
            assign x_eff = narrow_i ? {{(OFF_W-NARROW_W){1'b0}}, idx_x_i[NARROW_W-1:0]} : idx_x_i;
            assign y_eff = narrow_i ? {{(OFF_W-NARROW_W){1'b0}}, idx_y_i[NARROW_W-1:0]} : idx_y_i;
        end else begin : g_full
            assign x_eff = idx_x_i;
            assign y_eff = idx_y_i;
        end
    endgenerate

    logic [ADDR_W-1:0] long_base, long_sum;
    logic [OFF_W-1:0]  page_base, page_sum, add_idx, short_off;
    logic              use_long;

    assign short_off = {{(OFF_W-8){1'b0}}, operand_i[7:0]};

    always_comb begin
        long_base = operand_i;
        page_base = '0;
        add_idx   = '0;
        use_long  = 1'b1;
        case (mode_i)
            EA_ABS:        long_base = {dbank_i, operand_i[OFF_W-1:0]};
            EA_ABS_X: begin
                long_base = {dbank_i, operand_i[OFF_W-1:0]};
                add_idx   = x_eff;
            end
            EA_ABS_Y: begin
                long_base = {dbank_i, operand_i[OFF_W-1:0]};
                add_idx   = y_eff;
            end
            EA_LONG:       long_base = operand_i;
            EA_LONG_X:     add_idx   = x_eff;
            EA_IND_LONG:   long_base = ptr_i;
            EA_IND_LONG_Y: begin
                long_base = ptr_i;
                add_idx   = y_eff;
            end
            EA_DIR: begin
                use_long  = 1'b0;
                page_base = dpage_i + short_off;
            end
            EA_DIR_X: begin
                use_long  = 1'b0;
                page_base = dpage_i + short_off;
                add_idx   = x_eff;
            end
            EA_DIR_Y: begin
                use_long  = 1'b0;
                page_base = dpage_i + short_off;
                add_idx   = y_eff;
            end
            EA_STK: begin
                use_long  = 1'b0;
                page_base = sp_i + short_off;
            end
            default:       long_base = {dbank_i, operand_i[OFF_W-1:0]};
        endcase
        long_sum = long_base + {{BANK_W{1'b0}}, add_idx};
        page_sum = page_base + add_idx;
        ea_o     = use_long ? long_sum : {{BANK_W{1'b0}}, page_sum};
    end

endmodule

// File: rtl/bank_ea_gen.sv
module bank_ea_gen #(
    parameter int BANK_W = 8,
    parameter int OFF_W  = 16,
    localparam int ADDR_W = BANK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [OFF_W-1:0]  reg_wdata,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_load_val,
    input  logic              pc_step,
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] ptr_long,
    input  logic [OFF_W-1:0]  idx_x,
    input  logic [OFF_W-1:0]  idx_y,
    input  logic              idx_narrow,
    input  logic              addr_strobe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [OFF_W-1:0]  pc_out,
    output logic [BANK_W-1:0] pc_bank
);
    import bank_ea_pkg::*;

    logic [BANK_W-1:0] dbank;
    logic [OFF_W-1:0]  dpage, sp;
    logic [ADDR_W-1:0] ea;

    bank_ea_regs #(.BANK_W(BANK_W), .OFF_W(OFF_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .sel_i(reg_sel), .wdata_i(reg_wdata),
        .dbank_o(dbank), .dpage_o(dpage), .sp_o(sp)
    );

    bank_ea_pc #(.BANK_W(BANK_W), .OFF_W(OFF_W)) pc_i (
        .clk(clk), .rst_n(rst_n), .load_i(pc_load), .load_val_i(pc_load_val),
        .step_i(pc_step), .pc_o(pc_out), .bank_o(pc_bank)
    );

    bank_ea_calc #(.BANK_W(BANK_W), .OFF_W(OFF_W)) calc_i (
        .mode_i(mode), .operand_i(operand), .ptr_i(ptr_long), .idx_x_i(idx_x),
        .idx_y_i(idx_y), .narrow_i(idx_narrow), .dbank_i(dbank), .dpage_i(dpage),
        .sp_i(sp), .ea_o(ea)
    );

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (addr_strobe) st_d.addr = ea;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_addr = st_q.addr;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_strobe) |=> $stable(bus_addr)); // R9
    AST_STACK_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && mode == EA_STK) |=> bus_addr[ADDR_W-1:OFF_W] == '0); // R5
    AST_DIRECT_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && (mode == EA_DIR || mode == EA_DIR_X || mode == EA_DIR_Y))
        |=> bus_addr[ADDR_W-1:OFF_W] == '0); // R6
    AST_LONG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && mode == EA_LONG) |=> bus_addr == $past(operand)); // R4
    AST_IND_LONG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && mode == EA_IND_LONG) |=> bus_addr == $past(ptr_long)); // R3
    AST_ABS_DBANK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && mode == EA_ABS)
        |=> bus_addr == {$past(dbank), $past(operand[OFF_W-1:0])}); // R7

endmodule

// File: tb/bank_ea_gen_tb_top.sv
module bank_ea_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic        pc_load = 1'b0;
    logic [23:0] pc_load_val = '0;
    logic        pc_step = 1'b0;
    logic [3:0]  mode = '0;
    logic [23:0] operand = '0;
    logic [23:0] ptr_long = '0;
    logic [15:0] idx_x = '0;
    logic [15:0] idx_y = '0;
    logic        idx_narrow = 1'b0;
    logic        addr_strobe = 1'b0;
    logic [23:0] bus_addr;
    logic [15:0] pc_out;
    logic [7:0]  pc_bank;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bank_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .pc_load(pc_load), .pc_load_val(pc_load_val), .pc_step(pc_step), .mode(mode),
        .operand(operand), .ptr_long(ptr_long), .idx_x(idx_x), .idx_y(idx_y),
        .idx_narrow(idx_narrow), .addr_strobe(addr_strobe), .bus_addr(bus_addr),
        .pc_out(pc_out), .pc_bank(pc_bank)
    );

    typedef struct packed {
        logic [3:0]  m;
        logic [23:0] op;
        logic [23:0] ptr;
        logic [15:0] x;
        logic [15:0] y;
        logic        n8;
        logic [23:0] exp;
        logic [3:0]  rq;
    } vec_t;

    // Register setup before the table: data bank 0x12, direct page 0xFF80, stack 0x01F0
    localparam int NVEC = 15;
    localparam vec_t TBL [NVEC] = '{
        '{4'd0,  24'h003456, 24'h0,      16'h0,    16'h0,    1'b0, 24'h123456, 4'd7}, // R7
        '{4'd1,  24'h00FFF0, 24'h0,      16'h0020, 16'h0,    1'b0, 24'h130010, 4'd7}, // R7 carry
        '{4'd2,  24'h001000, 24'h0,      16'h0,    16'h1234, 1'b0, 24'h122234, 4'd7}, // R7
        '{4'd1,  24'h00FFF0, 24'h0,      16'hAB20, 16'h0,    1'b1, 24'h130010, 4'd8}, // R8
        '{4'd3,  24'h7FFFFE, 24'h0,      16'h0,    16'h0,    1'b0, 24'h7FFFFE, 4'd4}, // R4
        '{4'd4,  24'h7FFFFE, 24'h0,      16'h0005, 16'h0,    1'b0, 24'h800003, 4'd4}, // R4
        '{4'd4,  24'hFFFFFF, 24'h0,      16'h0001, 16'h0,    1'b0, 24'h000000, 4'd4}, // R4 top wrap
        '{4'd5,  24'hABCD90, 24'h0,      16'h0,    16'h0,    1'b0, 24'h000010, 4'd6}, // R6
        '{4'd6,  24'h000010, 24'h0,      16'h0100, 16'h0,    1'b0, 24'h000090, 4'd6}, // R6
        '{4'd7,  24'h000005, 24'h0,      16'h0,    16'h33FF, 1'b1, 24'h000084, 4'd8}, // R8
        '{4'd8,  24'h555520, 24'h0,      16'h0,    16'h0,    1'b0, 24'h000210, 4'd5}, // R5
        '{4'd9,  24'h0,      24'h456789, 16'h0,    16'h0,    1'b0, 24'h456789, 4'd3}, // R3
        '{4'd10, 24'h0,      24'h45FFF0, 16'h0,    16'h0020, 1'b0, 24'h460010, 4'd3}, // R3 carry
        '{4'd10, 24'h0,      24'h45FF00, 16'h0,    16'h8000, 1'b1, 24'h45FF00, 4'd8}, // R8
        '{4'd7,  24'h000090, 24'h0,      16'h0,    16'h0010, 1'b0, 24'h000020, 4'd6}  // R6
    };

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic gen(input logic [3:0] m, input logic [23:0] op, input logic [23:0] p,
                       input logic [15:0] x, input logic [15:0] y, input logic n8);
        mode = m; operand = op; ptr_long = p; idx_x = x; idx_y = y; idx_narrow = n8;
        addr_strobe = 1'b1;
        @(posedge clk); @(negedge clk);
        addr_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 reset bus_addr", bus_addr, 24'h0);
        chk("R9 reset pc", {pc_bank, pc_out}, 24'h0);
        gen(4'd0, 24'h001234, 24'h0, 16'h0, 16'h0, 1'b0);
        chk("R9 reset data bank", bus_addr, 24'h001234);

        wr_reg(2'd0, 16'h0012);
        wr_reg(2'd1, 16'hFF80);
        wr_reg(2'd2, 16'h01F0);
        wr_reg(2'd3, 16'hBEEF); // R10 reserved code
        gen(4'd0, 24'h003456, 24'h0, 16'h0, 16'h0, 1'b0);
        chk("R10 data bank after code 3", bus_addr, 24'h123456);
        gen(4'd8, 24'h000000, 24'h0, 16'h0, 16'h0, 1'b0);
        chk("R10 stack after code 3", bus_addr, 24'h0001F0);

        for (int k = 0; k < NVEC; k++) begin
            gen(TBL[k].m, TBL[k].op, TBL[k].ptr, TBL[k].x, TBL[k].y, TBL[k].n8);
            checks++;
            if (bus_addr !== TBL[k].exp) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual %h expected %h",
                         TBL[k].rq, k, bus_addr, TBL[k].exp);
            end
        end

        // R9 hold without strobe
        mode = 4'd3; operand = 24'hABCDEF; addr_strobe = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 hold", bus_addr, 24'h000020);

        // R5 stack wrap near top of bank zero
        wr_reg(2'd2, 16'hFFF0);
        gen(4'd8, 24'h000020, 24'h0, 16'h0, 16'h0, 1'b0);
        chk("R5 stack wrap", bus_addr, 24'h000010);

        // R1 program counter wrap within bank
        pc_load = 1'b1; pc_load_val = 24'h05FFFE;
        @(posedge clk); @(negedge clk);
        pc_load = 1'b0;
        chk("R2 load", {pc_bank, pc_out}, 24'h05FFFE);
        pc_step = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 step", {pc_bank, pc_out}, 24'h05FFFF);
        @(posedge clk); @(negedge clk);
        chk("R1 wrap keeps bank", {pc_bank, pc_out}, 24'h050000);
        pc_load = 1'b1; pc_load_val = 24'h0A1234;
        @(posedge clk); @(negedge clk);
        pc_load = 1'b0;
        chk("R2 load over step", {pc_bank, pc_out}, 24'h0A1234);
        @(posedge clk); @(negedge clk);
        pc_step = 1'b0;
        chk("R1 step after load", {pc_bank, pc_out}, 24'h0A1235);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule